// File: doc/BRIEF.md
# Contactless Tag Program/Verify Sequencer

This controller runs one complete programming session for a contactless memory tag. A start strobe makes it wake the tag with a short carrier burst and then drop the carrier for a gap. It then turns the carrier back on and collects the tag's readback. If the tag is blank, the sequencer starts programming passes through an external bit modulator. After every pass it compares the tag's verify stream with a 128-bit target word.

The pass policy is latched at start and comes in two forms. In fixed mode the sequencer runs a set number of passes back to back and judges only the last verify stream. In adaptive mode it stops once a verify stream matches, runs one extra margin pass and then reports success. If nothing has matched after a set number of passes, it reports failure. A readback that shows no modulation means the tag never recognised the burst. The sequencer reports this as a separate level-calibration fault. In 96-bit length mode, one band of target bits is left out of every comparison.

Top module: `tag_prog_seq`

## Requirements
- R1: A start strobe in the idle or done state turns the carrier on (`carrier_en`=1) for exactly PWR_CYCLES carrier ticks. With the default 8 µs tick this is 128 µs, inside the 80–180 µs wake window.
- R2: The burst is followed by exactly GAP_CYCLES ticks with `carrier_en`=0 (80 µs by default, inside the 50–100 µs gap window). The carrier then turns back on to collect the readback.
- R3: The blank readback consists of NBITS bits on `rb_valid`. If any of them is 0, the session ends with status 8'h6E ('n') and `mod_start` never pulses.
- R4: A `rb_nomod` pulse during any readback ends the session with status 8'h63 ('c', calibration fault), whatever the bits already received.
- R5: In fixed mode (`adaptive`=0) exactly FIXED_PASSES (10) programming passes run. Only the verify stream after the last pass decides the result: 8'h76 ('v') if it matches, 8'h6E ('n') if not. Earlier mismatches have no effect.
- R6: In adaptive mode, the first matching verify stream is followed by exactly one more programming pass. Status 8'h76 is reported when that pass ends, with no further readback.
- R7: In adaptive mode, if none of MAX_PASSES (16) verify streams matches, the session ends with 8'h6E after exactly MAX_PASSES passes.
- R8: Readback bit k (k = 0 first) is compared with `target[k]`. When `len96` is 1, indices 32..63 are ignored. When it is 0, all 128 indices count.
- R9: Once `mod_start` has pulsed, the sequencer holds `carrier_prog`=1 until `mod_done`. A start strobe during a pass has no effect.
- R10: After reset, `carrier_en`, `carrier_prog`, `mod_start` and `status_valid` are 0. In the done state, `status_valid`=1 and `status_code` hold steady until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_tick | input | 1 | One pulse per carrier cycle |
| start | input | 1 | Session start strobe |
| adaptive | input | 1 | 1 = adaptive pass policy, 0 = fixed count (latched at start) |
| len96 | input | 1 | 1 = 96-bit length mode (latched at start) |
| target | input | 128 | Data to be programmed; bit k is the k-th bit of a stream |
| rb_valid | input | 1 | A decoded readback bit is present |
| rb_bit | input | 1 | Decoded readback bit value |
| rb_nomod | input | 1 | Readback shows no modulation |
| mod_done | input | 1 | Bit modulator finished the current pass |
| carrier_en | output | 1 | Carrier on |
| carrier_prog | output | 1 | Level select: 1 hands the drive level to the modulator |
| mod_start | output | 1 | One-cycle strobe that starts a programming pass |
| status_valid | output | 1 | Session finished, status_code valid |
| status_code | output | 8 | 8'h76 success, 8'h6E failure, 8'h63 calibration fault |

## Verification
The bench goes after the pass-count boundaries. It uses a first match on the first, third and tenth pass, and a stream that never matches. A fixed-mode design that stopped early, or that judged an earlier verify stream, reports the wrong code or the wrong number of passes. An adaptive design that skipped or doubled the margin pass is off by one in the pass count. The bench corrupts only the masked band and runs that stream in both length modes, so a wrong mask shows up as success in 128-bit mode or failure in 96-bit mode. It sends no-modulation both at the blank read and at a verify read, so a design that treated it as plain non-blank data would report 'n' instead of 'c'. It strobes start in the middle of a pass, which shows any design that abandons the pass.

// File: rtl/tps_pkg.sv
// Shared types and status codes for the tag program/verify sequencer.
package tps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_GAP,
        ST_BLANK,
        ST_PROG,
        ST_VERIFY,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] CODE_OK     = 8'h76;
    localparam logic [7:0] CODE_NOPROG = 8'h6E;
    localparam logic [7:0] CODE_CAL    = 8'h63;
endpackage

// File: rtl/tps_phase_timer.sv
// Counts carrier ticks while run is high and pulses expired on the tick
// that completes limit ticks; the count restarts after expiry.
// Assumes limit >= 1 and that limit only changes together with expiry.
module tps_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = run && tick && ((cnt + 1'b1) == limit);

    // Tick counter, cleared when idle or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) cnt <= '0;
        else if (tick)                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tps_rb_compare.sv
// Collects one readback stream of NBITS bits and compares it on the fly,
// either against all ones (blank check) or against ref_vec where care_vec is set.
// Assumes en stays high for the whole stream and drops between streams.
module tps_rb_compare #(
    parameter int NBITS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             blank_chk,
    input  logic             rb_valid,
    input  logic             rb_bit,
    input  logic [NBITS-1:0] ref_vec,
    input  logic [NBITS-1:0] care_vec,
    output logic             done,
    output logic             match
);
    localparam int IDX_W = $clog2(NBITS);

    logic [IDX_W-1:0] idx;
    logic             mism;
    logic             exp_bit;
    logic             cared;
    logic             bad;

    // Expected value and mismatch of the bit arriving now.
    always_comb begin
        exp_bit = blank_chk ? 1'b1 : ref_vec[idx];
        cared   = blank_chk | care_vec[idx];
        bad     = en && rb_valid && cared && (rb_bit != exp_bit);
    end

    assign done  = en && rb_valid && (idx == IDX_W'(NBITS - 1));
    assign match = !(mism || bad);

    // Bit index and sticky mismatch flag for the current stream.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idx  <= '0;
            mism <= 1'b0;
        end else if (rb_valid) begin
            idx  <= idx + 1'b1;
            mism <= mism | bad;
        end
    end
endmodule

// File: rtl/tag_prog_seq.sv
// Session controller for a contactless tag programmer: wake burst, gap,
// blank check, program/verify passes under a fixed or adaptive policy, status.
// Assumes target is stable during a session and the modulator answers every
// mod_start with one mod_done.
module tag_prog_seq
    import tps_pkg::*;
#(
    parameter int NBITS        = 128,
    parameter int PWR_CYCLES   = 16,
    parameter int GAP_CYCLES   = 10,
    parameter int FIXED_PASSES = 10,
    parameter int MAX_PASSES   = 16,
    parameter int MASK_LO      = 32,
    parameter int MASK_HI      = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_tick,
    input  logic             start,
    input  logic             adaptive,
    input  logic             len96,
    input  logic [NBITS-1:0] target,
    input  logic             rb_valid,
    input  logic             rb_bit,
    input  logic             rb_nomod,
    input  logic             mod_done,
    output logic             carrier_en,
    output logic             carrier_prog,
    output logic             mod_start,
    output logic             status_valid,
    output logic [7:0]       status_code
);
    localparam int PH_MAX  = (PWR_CYCLES > GAP_CYCLES) ? PWR_CYCLES : GAP_CYCLES;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int PASS_MX = (FIXED_PASSES > MAX_PASSES + 1) ? FIXED_PASSES : MAX_PASSES + 1;
    localparam int PASS_W  = $clog2(PASS_MX + 1);

    seq_state_t        state, state_n;
    logic [7:0]        code_q, code_n;
    logic              margin_q, margin_set;
    logic [PASS_W-1:0] pass_cnt;
    logic              adapt_q, len96_q;
    logic              mod_start_q;
    logic              t_run, t_exp;
    logic [PH_W-1:0]   t_limit;
    logic              rd_en, rd_done, rd_match;
    logic [NBITS-1:0]  care;

    // Comparison mask: one entry per bit, band dropped in 96-bit mode.
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_care
        if (gi >= MASK_LO && gi <= MASK_HI) begin : g_band
            assign care[gi] = !len96_q;
        end else begin : g_keep
            assign care[gi] = 1'b1;
        end
    end

    assign t_run   = (state == ST_PWR) || (state == ST_GAP);
    assign t_limit = (state == ST_PWR) ? PH_W'(PWR_CYCLES) : PH_W'(GAP_CYCLES);
    assign rd_en   = (state == ST_BLANK) || (state == ST_VERIFY);

    tps_phase_timer #(.CNT_W(PH_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (t_run),
        .tick    (carrier_tick),
        .limit   (t_limit),
        .expired (t_exp)
    );

    tps_rb_compare #(.NBITS(NBITS)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rd_en),
        .blank_chk (state == ST_BLANK),
        .rb_valid  (rb_valid),
        .rb_bit    (rb_bit),
        .ref_vec   (target),
        .care_vec  (care),
        .done      (rd_done),
        .match     (rd_match)
    );

    // Next-state, result code and margin decision.
    always_comb begin
        state_n    = state;
        code_n     = code_q;
        margin_set = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) state_n = ST_PWR;
            ST_PWR:           if (t_exp) state_n = ST_GAP;
            ST_GAP:           if (t_exp) state_n = ST_BLANK;
            ST_BLANK: begin
                if (rb_nomod) begin
                    state_n = ST_DONE;
                    code_n  = CODE_CAL;
                end else if (rd_done) begin
                    if (rd_match) state_n = ST_PROG;
                    else begin
                        state_n = ST_DONE;
                        code_n  = CODE_NOPROG;
                    end
                end
            end
            ST_PROG: begin
                if (mod_done) begin
                    if (adapt_q && margin_q) begin
                        state_n = ST_DONE;
                        code_n  = CODE_OK;
                    end else state_n = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (rb_nomod) begin
                    state_n = ST_DONE;
                    code_n  = CODE_CAL;
                end else if (rd_done) begin
                    if (adapt_q) begin
                        if (rd_match) begin
                            state_n    = ST_PROG;
                            margin_set = 1'b1;
                        end else if (pass_cnt >= PASS_W'(MAX_PASSES)) begin
                            state_n = ST_DONE;
                            code_n  = CODE_NOPROG;
                        end else state_n = ST_PROG;
                    end else if (pass_cnt >= PASS_W'(FIXED_PASSES)) begin
                        state_n = ST_DONE;
                        code_n  = rd_match ? CODE_OK : CODE_NOPROG;
                    end else state_n = ST_PROG;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Session registers: state, code, pass count, latched policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            code_q      <= '0;
            margin_q    <= 1'b0;
            pass_cnt    <= '0;
            adapt_q     <= 1'b0;
            len96_q     <= 1'b0;
            mod_start_q <= 1'b0;
        end else begin
            state       <= state_n;
            code_q      <= code_n;
            mod_start_q <= (state_n == ST_PROG) && (state != ST_PROG);
            if ((state == ST_IDLE || state == ST_DONE) && start) begin
                pass_cnt <= '0;
                margin_q <= 1'b0;
                adapt_q  <= adaptive;
                len96_q  <= len96;
            end else begin
                if (margin_set) margin_q <= 1'b1;
                if ((state_n == ST_PROG) && (state != ST_PROG)) pass_cnt <= pass_cnt + 1'b1;
            end
        end
    end

    assign carrier_en   = (state == ST_PWR) || (state == ST_BLANK) ||
                          (state == ST_PROG) || (state == ST_VERIFY);
    assign carrier_prog = (state == ST_PROG);
    assign mod_start    = mod_start_q;
    assign status_valid = (state == ST_DONE);
    assign status_code  = code_q;
endmodule

// File: rtl/tag_prog_seq_chk.sv
// Property checker for tag_prog_seq, attached by bind. Measures the burst
// and gap in ticks and checks them against the allowed windows in ns.
module tag_prog_seq_chk
    import tps_pkg::*;
#(
    parameter int CYCLE_NS     = 8000,
    parameter int FIXED_PASSES = 10,
    parameter int MAX_PASSES   = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       carrier_tick,
    input logic       start,
    input logic       rb_nomod,
    input logic       mod_done,
    input logic       carrier_prog,
    input logic       mod_start,
    input logic       status_valid,
    input logic [7:0] status_code,
    input seq_state_t state,
    input logic [7:0] pass_cnt,
    input logic       rd_done,
    input logic       rd_match
);
    localparam int PASS_CAP = (FIXED_PASSES > MAX_PASSES + 1) ? FIXED_PASSES : MAX_PASSES + 1;

    logic [15:0] pw_ticks, gap_ticks;

    // Tick counts of the current burst and gap, cleared between sessions.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE || state == ST_DONE) begin
            pw_ticks  <= '0;
            gap_ticks <= '0;
        end else begin
            if (state == ST_PWR && carrier_tick) pw_ticks  <= pw_ticks + 1'b1;
            if (state == ST_GAP && carrier_tick) gap_ticks <= gap_ticks + 1'b1;
        end
    end

    assert_burst_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && $past(state) == ST_PWR) |->
        (int'(pw_ticks) * CYCLE_NS >= 80000 && int'(pw_ticks) * CYCLE_NS <= 180000));

    assert_gap_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && $past(state) == ST_GAP) |->
        (int'(gap_ticks) * CYCLE_NS >= 50000 && int'(gap_ticks) * CYCLE_NS <= 100000));

    assert_blank_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && rd_done && !rd_match && !rb_nomod) |=>
        (status_valid && status_code == CODE_NOPROG && !mod_start));

    assert_nomod_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BLANK || state == ST_VERIFY) && rb_nomod) |=>
        (status_valid && status_code == CODE_CAL));

    assert_pass_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pass_cnt) <= PASS_CAP);

    assert_prog_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_prog && !mod_done) |=> carrier_prog);

    assert_start_is_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mod_start |-> carrier_prog);

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && !start) |=> (status_valid && $stable(status_code)));
endmodule

bind tag_prog_seq tag_prog_seq_chk #(
    .CYCLE_NS     (8000),
    .FIXED_PASSES (FIXED_PASSES),
    .MAX_PASSES   (MAX_PASSES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_tick (carrier_tick),
    .start        (start),
    .rb_nomod     (rb_nomod),
    .mod_done     (mod_done),
    .carrier_prog (carrier_prog),
    .mod_start    (mod_start),
    .status_valid (status_valid),
    .status_code  (status_code),
    .state        (state),
    .pass_cnt     (8'(pass_cnt)),
    .rd_done      (rd_done),
    .rd_match     (rd_match)
);

// File: tb/tag_prog_seq_tb.sv
module tag_prog_seq_tb;
    localparam logic [127:0] TGT = 128'hC3A5_96F0_1E2D_4B78_8765_4321_0FED_CBA9;

    // fault: 0 none, 1 zero in blank read, 2 nomod at blank, 3 nomod at first verify
    typedef struct packed {
        logic       adapt;
        logic       m96;
        logic [1:0] fault;
        logic [4:0] good_from;
        logic       corrupt;
        logic [7:0] code;
        logic [4:0] passes;
    } scen_t;

    localparam scen_t SCN [12] = '{
        '{1'b0, 1'b0, 2'd0, 5'd3,  1'b0, 8'h76, 5'd10}, // R5 early match, still 10
        '{1'b0, 1'b0, 2'd0, 5'd0,  1'b0, 8'h6E, 5'd10}, // R5 never
        '{1'b0, 1'b0, 2'd0, 5'd10, 1'b0, 8'h76, 5'd10}, // R5 only last matches
        '{1'b0, 1'b0, 2'd0, 5'd11, 1'b0, 8'h6E, 5'd10}, // R5 match too late
        '{1'b1, 1'b0, 2'd0, 5'd3,  1'b0, 8'h76, 5'd4},  // R6 margin after pass 3
        '{1'b1, 1'b0, 2'd0, 5'd1,  1'b0, 8'h76, 5'd2},  // R6 first pass matches
        '{1'b1, 1'b0, 2'd0, 5'd0,  1'b0, 8'h6E, 5'd16}, // R7 give up
        '{1'b1, 1'b1, 2'd0, 5'd1,  1'b1, 8'h76, 5'd2},  // R8 band masked
        '{1'b1, 1'b0, 2'd0, 5'd1,  1'b1, 8'h6E, 5'd16}, // R8 band counted
        '{1'b0, 1'b0, 2'd1, 5'd0,  1'b0, 8'h6E, 5'd0},  // R3 not blank
        '{1'b0, 1'b0, 2'd2, 5'd0,  1'b0, 8'h63, 5'd0},  // R4 nomod blank
        '{1'b1, 1'b0, 2'd3, 5'd1,  1'b0, 8'h63, 5'd1}   // R4 nomod verify
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         carrier_tick = 1'b0;
    logic         start = 1'b0;
    logic         adaptive = 1'b0;
    logic         len96 = 1'b0;
    logic [127:0] target = TGT;
    logic         rb_valid = 1'b0;
    logic         rb_bit = 1'b0;
    logic         rb_nomod = 1'b0;
    logic         mod_done = 1'b0;
    logic         carrier_en, carrier_prog, mod_start, status_valid;
    logic [7:0]   status_code;

    int checks = 0;
    int errors = 0;
    int pw_seen, gap_seen, pass_seen;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Carrier tick every second clock.
    always @(posedge clk) carrier_tick <= ~carrier_tick;

    tag_prog_seq u_dut (
        .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .start(start),
        .adaptive(adaptive), .len96(len96), .target(target),
        .rb_valid(rb_valid), .rb_bit(rb_bit), .rb_nomod(rb_nomod), .mod_done(mod_done),
        .carrier_en(carrier_en), .carrier_prog(carrier_prog), .mod_start(mod_start),
        .status_valid(status_valid), .status_code(status_code)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
        end
    endtask

    task automatic send_stream(input logic [127:0] bits);
        for (int i = 0; i < 128; i++) begin
            rb_valid = 1'b1;
            rb_bit   = bits[i];
            @(negedge clk);
        end
        rb_valid = 1'b0;
    endtask

    task automatic pulse_nomod();
        rb_nomod = 1'b1;
        @(negedge clk);
        rb_nomod = 1'b0;
    endtask

    task automatic run_session(input scen_t s, input bit poke_start);
        logic [127:0] bits;
        adaptive = s.adapt;
        len96    = s.m96;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        while (!carrier_en) @(negedge clk);
        pw_seen = 0;
        while (carrier_en) begin
            if (carrier_tick) pw_seen++;
            @(negedge clk);
        end
        gap_seen = 0;
        while (!carrier_en) begin
            if (carrier_tick) gap_seen++;
            @(negedge clk);
        end
        if (s.fault == 2'd2) pulse_nomod();
        else begin
            bits = '1;
            if (s.fault == 2'd1) bits[7] = 1'b0;
            send_stream(bits);
        end
        pass_seen = 0;
        while (!status_valid) begin
            if (mod_start) begin
                pass_seen++;
                if (poke_start && pass_seen == 1) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    repeat (30) @(negedge clk);
                    chk(carrier_prog && !status_valid, "R9 pass held through start", carrier_prog, 1);
                end
                repeat (10) @(negedge clk);
                mod_done = 1'b1;
                @(negedge clk);
                mod_done = 1'b0;
                repeat (2) @(negedge clk);
                if (!status_valid) begin
                    if (s.fault == 2'd3 && pass_seen == 1) pulse_nomod();
                    else begin
                        bits = TGT;
                        if (s.good_from != 0 && pass_seen >= s.good_from) begin
                            if (s.corrupt) bits[63:32] = ~bits[63:32];
                        end else bits[5] = ~bits[5];
                        send_stream(bits);
                    end
                end
            end else @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!carrier_en && !carrier_prog && !mod_start && !status_valid,
            "R10 outputs in reset", {carrier_en, carrier_prog, mod_start, status_valid}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!carrier_en && !status_valid, "R10 idle after reset", {carrier_en, status_valid}, 0);

        for (int n = 0; n < 12; n++) begin
            run_session(SCN[n], 1'b0);
            chk(pw_seen == 16, $sformatf("R1 burst ticks scen %0d", n), pw_seen, 16);
            chk(pw_seen * 8 >= 80 && pw_seen * 8 <= 180, "R1 burst us", pw_seen * 8, 128);
            chk(gap_seen == 10, $sformatf("R2 gap ticks scen %0d", n), gap_seen, 10);
            chk(gap_seen * 8 >= 50 && gap_seen * 8 <= 100, "R2 gap us", gap_seen * 8, 80);
            chk(status_code == SCN[n].code,
                $sformatf("R3/R4/R5/R6/R7/R8 code scen %0d", n), status_code, SCN[n].code);
            chk(pass_seen == int'(SCN[n].passes),
                $sformatf("R5/R6/R7 pass count scen %0d", n), pass_seen, SCN[n].passes);
        end

        // R10: status held while idle in done state.
        repeat (20) @(negedge clk);
        chk(status_valid && status_code == 8'h63, "R10 status hold", status_code, 8'h63);

        // R9: start strobe in mid-pass is ignored.
        run_session('{1'b1, 1'b0, 2'd0, 5'd1, 1'b0, 8'h76, 5'd2}, 1'b1);
        chk(status_code == 8'h76, "R9 session completes after mid-pass start", status_code, 8'h76);
        chk(pass_seen == 2, "R9 pass count after mid-pass start", pass_seen, 2);

        // R10: reset mid-session clears outputs.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!carrier_en && !status_valid, "R10 reset mid-session", carrier_en, 0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule